// File: doc/BRIEF.md
# Iterative Signed Divider With Remainder

This block divides one signed 32-bit integer by another and returns either the quotient or the remainder. It follows the integer semantics of the C language: the quotient is truncated toward zero and the remainder carries the sign of the dividend. Both values always satisfy dividend = quotient × divisor + remainder. The magnitudes come from restoring long division. Each cycle, the next dividend bit is shifted into a partial remainder. The divisor is subtracted whenever it fits, and the resulting quotient bit is recorded. A final cycle restores the signs.

A request carries the dividend, the divisor and a select bit, and is accepted on a valid/ready handshake. The answer appears on `result` during the single cycle in which `done` is high. The block keeps the operands and both results of the last completed division. A later request with identical operands, such as a remainder request following a quotient request, is answered on the next cycle without iterating. Division by zero and the single overflowing case both produce defined values and never trap.

The controller has three states. In IDLE it waits and accepts requests. RUN performs the shift/subtract steps. FIX applies the signs, stores the results and raises `done`. The transitions are:
- IDLE→RUN when a fresh request is accepted.
- IDLE→IDLE when a request hits the stored operands.
- RUN→RUN while steps remain.
- RUN→FIX after the last step.
- FIX→IDLE unconditionally.

Top module: `sdiv_unit`

## Requirements
- R1: After reset `req_ready` is 1 and `done` is 0. `req_ready` is 1 exactly when no division is in progress.
- R2: With `req_sel_rem`=0 the result is the signed quotient truncated toward zero. With `req_sel_rem`=1 it is the remainder, which has the sign of the dividend, so dividend = quotient × divisor + remainder.
- R3: A divisor of zero yields a quotient of all ones (-1) and a remainder equal to the dividend.
- R4: Dividing -2^31 by -1 yields a quotient of -2^31 (0x80000000) and a remainder of 0.
- R5: A request that misses the stored operands is a fresh request. Its `done` rises 33 cycles after the accepting clock edge: 32 step cycles plus one sign-fixup cycle. `req_ready` is 0 from the edge after acceptance until `done`.
- R6: A request whose dividend and divisor both equal those of the last completed fresh division raises `done` on the cycle after acceptance, with the stored quotient or remainder. `req_ready` stays 1.
- R7: `done` is high for exactly one cycle per accepted request, and `result` is meaningful only in that cycle.
- R8: Reset forgets the stored operands. The stored operands are replaced only by a fresh division. A request that differs in either operand runs the full division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Divider can take a request this cycle |
| req_dividend | input | 32 | Signed dividend |
| req_divisor | input | 32 | Signed divisor |
| req_sel_rem | input | 1 | 0 selects quotient, 1 selects remainder |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | 32 | Quotient or remainder as selected |

## Verification
A wrong step count or a stuck state shows up at the ports as `done` arriving off its 33-cycle slot, or never arriving at all. This is caught by the first fresh request after the fault. A corrupted partial remainder or a wrong quotient bit shows up in that same request's result, and the rest of the quotient/remainder pair inherits it from storage one cycle later. A stored-operand register that keeps stale data, or that survives reset, changes the latency of the next repeated request from 1 cycle to 33, or the reverse. That is detected on that request.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIX  = 2'd2
    } div_state_t;
endpackage

// File: rtl/sdiv_core.sv
// Restoring shift/subtract datapath operating on unsigned magnitudes.
module sdiv_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] num_mag,
    input  logic [WIDTH-1:0] den_mag,
    output logic [WIDTH-1:0] quo_mag,
    output logic [WIDTH-1:0] rem_mag
);
    logic [WIDTH-1:0] part_q;
    logic [WIDTH-1:0] quo_q;
    logic [WIDTH-1:0] den_q;
    logic [WIDTH:0]   shifted;
    logic [WIDTH:0]   trial;
    logic             fits;

    always_comb begin
        shifted = {part_q, quo_q[WIDTH-1]};
        trial   = shifted - {1'b0, den_q};
        fits    = (shifted >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= '0;
            quo_q  <= '0;
            den_q  <= '0;
        end else if (load) begin
            part_q <= '0;
            quo_q  <= num_mag;
            den_q  <= den_mag;
        end else if (step) begin
            part_q <= fits ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
            quo_q  <= {quo_q[WIDTH-2:0], fits};
        end
    end

    assign quo_mag = quo_q;
    assign rem_mag = part_q;

    // R2: a step never leaves a partial remainder at or above a nonzero divisor
    part_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && den_q != '0) |=> (part_q < den_q));
endmodule

// File: rtl/sdiv_fix.sv
// Sign restoration and the zero-divisor override.
module sdiv_fix #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] num,
    input  logic [WIDTH-1:0] den,
    input  logic [WIDTH-1:0] quo_mag,
    input  logic [WIDTH-1:0] rem_mag,
    output logic [WIDTH-1:0] quo,
    output logic [WIDTH-1:0] rem
);
    logic neg_q;
    logic neg_r;
    logic den_zero;

    always_comb begin
        neg_q    = num[WIDTH-1] ^ den[WIDTH-1];
        neg_r    = num[WIDTH-1];
        den_zero = (den == '0);
        if (den_zero) begin
            quo = '1;
            rem = num;
        end else begin
            quo = neg_q ? (~quo_mag + 1'b1) : quo_mag;
            rem = neg_r ? (~rem_mag + 1'b1) : rem_mag;
        end
    end
endmodule

// File: rtl/sdiv_memo.sv
// Holds the operands and both results of the last completed fresh division.
module sdiv_memo #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wr_num,
    input  logic [WIDTH-1:0] wr_den,
    input  logic [WIDTH-1:0] wr_quo,
    input  logic [WIDTH-1:0] wr_rem,
    input  logic [WIDTH-1:0] look_num,
    input  logic [WIDTH-1:0] look_den,
    output logic             hit,
    output logic [WIDTH-1:0] hit_quo,
    output logic [WIDTH-1:0] hit_rem
);
    logic             live_q;
    logic [WIDTH-1:0] num_q;
    logic [WIDTH-1:0] den_q;
    logic [WIDTH-1:0] quo_q;
    logic [WIDTH-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            num_q  <= '0;
            den_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
        end else if (wr) begin
            live_q <= 1'b1;
            num_q  <= wr_num;
            den_q  <= wr_den;
            quo_q  <= wr_quo;
            rem_q  <= wr_rem;
        end
    end

    assign hit     = live_q && (look_num == num_q) && (look_den == den_q);
    assign hit_quo = quo_q;
    assign hit_rem = rem_q;

    // R8
    memo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(num_q) && $stable(den_q) && $stable(quo_q) && $stable(rem_q)));
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
    import sdiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [WIDTH-1:0] req_dividend,
    input  logic [WIDTH-1:0] req_divisor,
    input  logic             req_sel_rem,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);
    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

    div_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [WIDTH-1:0] num_q, den_q;
    logic             sel_q;
    logic             accept, hit, fresh;
    logic             memo_hit;
    logic [WIDTH-1:0] memo_quo, memo_rem;
    logic [WIDTH-1:0] num_mag, den_mag, quo_mag, rem_mag;
    logic [WIDTH-1:0] fix_quo, fix_rem;
    logic             done_q;
    logic [WIDTH-1:0] result_q;

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign hit       = accept && memo_hit;
    assign fresh     = accept && !memo_hit;
    assign num_mag   = req_dividend[WIDTH-1] ? (~req_dividend + 1'b1) : req_dividend;
    assign den_mag   = req_divisor[WIDTH-1]  ? (~req_divisor + 1'b1)  : req_divisor;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (fresh) state_d = S_RUN;
            S_RUN:   if (cnt_q == LAST_STEP) state_d = S_FIX;
            S_FIX:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register, step counter and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            num_q   <= '0;
            den_q   <= '0;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (fresh) begin
                cnt_q <= '0;
                num_q <= req_dividend;
                den_q <= req_divisor;
                sel_q <= req_sel_rem;
            end else if (state_q == S_RUN) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (hit) begin
                done_q   <= 1'b1;
                result_q <= req_sel_rem ? memo_rem : memo_quo;
            end else if (state_q == S_FIX) begin
                done_q   <= 1'b1;
                result_q <= sel_q ? fix_rem : fix_quo;
            end
        end
    end

    assign done   = done_q;
    assign result = result_q;

    sdiv_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fresh),
        .step    (state_q == S_RUN),
        .num_mag (num_mag),
        .den_mag (den_mag),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag)
    );

    sdiv_fix #(.WIDTH(WIDTH)) u_fix (
        .num     (num_q),
        .den     (den_q),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag),
        .quo     (fix_quo),
        .rem     (fix_rem)
    );

    sdiv_memo #(.WIDTH(WIDTH)) u_memo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (state_q == S_FIX),
        .wr_num   (num_q),
        .wr_den   (den_q),
        .wr_quo   (fix_quo),
        .wr_rem   (fix_rem),
        .look_num (req_dividend),
        .look_den (req_divisor),
        .hit      (memo_hit),
        .hit_quo  (memo_quo),
        .hit_rem  (memo_rem)
    );

    // R5
    fresh_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |=> !req_ready);

    // R5
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && cnt_q != LAST_STEP) |=> (state_q == S_RUN && !done));

    // R6
    memo_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (done && req_ready));

    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state_q == S_FIX || hit));

    // R2
    identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIX && den_q != '0) |->
        ({{WIDTH{1'b0}}, quo_mag} * {{WIDTH{1'b0}}, den_mag_q()} + {{WIDTH{1'b0}}, rem_mag}
            == {{WIDTH{1'b0}}, num_mag_q()}));

    // R4
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FIX && num_q == MOST_NEG && den_q == '1) |->
        (fix_quo == MOST_NEG && fix_rem == '0));

    function automatic logic [WIDTH-1:0] num_mag_q();
        return num_q[WIDTH-1] ? (~num_q + 1'b1) : num_q;
    endfunction

    function automatic logic [WIDTH-1:0] den_mag_q();
        return den_q[WIDTH-1] ? (~den_q + 1'b1) : den_q;
    endfunction
endmodule

// File: tb/sim_sdiv_unit.sv
`timescale 1ns/1ps
module sim_sdiv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_dividend = '0;
    logic [31:0] req_divisor = '0;
    logic        req_sel_rem = 1'b0;
    logic        done;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        logic [31:0] val;
        int          at;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic        m_live = 1'b0;
    logic [31:0] m_a, m_b;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    sdiv_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dividend(req_dividend), .req_divisor(req_divisor), .req_sel_rem(req_sel_rem),
        .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, input bit r);
        if (b == 0) return r ? a : 32'hFFFF_FFFF;                        // R3
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return r ? 32'h0 : 32'h8000_0000; // R4
        return r ? ($signed(a) % $signed(b)) : ($signed(a) / $signed(b)); // R2
    endfunction

    // Driver: pushes the expected item, then offers the request
    task automatic send(input logic [31:0] a, input logic [31:0] b, input bit r, input string tag);
        bit   h;
        int   acc;
        exp_t e;
        req_dividend = a;
        req_divisor  = b;
        req_sel_rem  = r;
        req_valid    = 1'b1;
        while (!req_ready) @(negedge clk);
        acc   = cyc + 1;
        h     = m_live && (a == m_a) && (b == m_b);
        e.val = model(a, b, r);
        e.at  = h ? acc : acc + 33;      // R5 / R6 latency
        e.tag = h ? {tag, " R6"} : {tag, " R5"};
        sb.push_back(e);
        if (!h) begin
            m_live = 1'b1;
            m_a = a;
            m_b = b;
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (!h) chk(req_ready == 1'b0, "R5 ready low while busy", {31'b0, req_ready}, 32'h0);
        else    chk(req_ready == 1'b1, "R6 ready stays high", {31'b0, req_ready}, 32'h1);
    endtask

    task automatic pair(input logic [31:0] a, input logic [31:0] b, input string tag);
        send(a, b, 1'b0, tag);
        send(a, b, 1'b1, tag);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R7 unexpected done", result, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(result == e.val, {"R2 value ", e.tag}, result, e.val);
                chk(cyc == e.at, {"latency ", e.tag}, cyc, e.at);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 32'h0, 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [31:0] x;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", {31'b0, req_ready}, 32'h1);
        chk(done == 1'b0, "R1 done after reset", {31'b0, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        pair(32'd100, 32'd7, "R2 pos/pos");
        pair(-32'sd100, 32'd7, "R2 neg/pos");
        pair(32'd100, -32'sd7, "R2 pos/neg");
        pair(-32'sd100, -32'sd7, "R2 neg/neg");
        pair(32'd7, 32'd100, "R2 small");
        pair(32'd55, 32'd0, "R3 zero");
        send(-32'sd9, 32'd0, 1'b1, "R3 neg zero rem");
        send(-32'sd9, 32'd0, 1'b0, "R3 neg zero quo");
        pair(32'h8000_0000, 32'hFFFF_FFFF, "R4 ovf");
        pair(32'h7FFF_FFFF, 32'h8000_0000, "R2 extremes");
        send(32'd1000, 32'd9, 1'b0, "R8 base");
        send(32'd1000, 32'd10, 1'b1, "R8 divisor change");
        send(32'd1001, 32'd10, 1'b1, "R8 dividend change");
        send(32'd1001, 32'd10, 1'b0, "R6 repeat");
        drain();

        // R8: reset forgets stored operands
        rst_n = 1'b0;
        m_live = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0, "R1 idle in reset", {30'b0, req_ready, done}, 32'h2);
        rst_n = 1'b1;
        @(negedge clk);
        send(32'd1001, 32'd10, 1'b0, "R8 after reset");

        x = 32'h1234_5679;
        for (int i = 0; i < 16; i++) begin
            logic [31:0] a, b;
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            a = x;
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            b = (i % 3 == 0) ? {{24{x[31]}}, x[7:0]} : x;
            pair(a, b, "R2 sweep");
        end
        drain();
        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R7 scoreboard empty", sb.size(), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule